// File: doc/BRIEF.md
# Camera Pixel Capture Into a Frame Buffer

This block sits on the pixel-clock side of a camera input path. It samples an 8-bit byte stream together with a frame sync and a line-valid strobe. It combines byte pairs into pixels and emits one memory write per pixel into a dual-port frame buffer. A separate display reader scans that buffer out on its own port.

In colour mode, each pixel arrives as a 16-bit RGB565 value: the high byte comes first, then the low byte. The block keeps only the top `CH_W` bits of each channel and packs them into a narrow memory word. In luma-only mode, the stream is treated as YUV pairs. Only the luma byte is kept, which is the first byte of each pair, and it is stored zero-extended. The frame sync clears the write address, so every frame lands at address 0 onward. The line-valid strobe decides which bytes count.

Top module: `pix_capture_fb`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `wr_en`, `wr_addr` and `wr_data` are all zero.
- R2: In colour mode (`luma_sel`=0), the byte pair hi,lo forms word w={hi,lo}, where red is w[15:11], green is w[10:5] and blue is w[4:0]. The block writes `wr_data` = {w[15:12], w[10:7], w[4:1]}: red in bits 11:8, green in 7:4 and blue in 3:0.
- R3: In luma-only mode (`luma_sel`=1, sampled on the clock edge of the pair's second byte), `wr_data` is the first byte of the pair, zero-extended, so bits 11:8 are 0.
- R4: `wr_en` is high for exactly one cycle, starting on the clock edge after the edge that samples the second byte of a pair. It is never high in two consecutive cycles.
- R5: A low `cam_href` resets the byte phase. The first valid byte of every line is the high byte of a pixel. A leftover odd byte at the end of a line is discarded without a write.
- R6: While `cam_vsync` is high, bytes are ignored and no write is issued. The first write after `cam_vsync` falls goes to address 0.
- R7: Within one frame, each write uses the address one above the previous write.
- R8: After the write to address FRAME_W*FRAME_H-1, no further write happens until `cam_vsync` is raised again.
- R9: Bytes presented while `cam_href` is low produce no write and do not alter any later pixel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Camera pixel clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_sel | input | 1 | 1 = keep luma byte only, 0 = RGB565 colour packing |
| cam_vsync | input | 1 | Frame sync, active high |
| cam_href | input | 1 | Line valid, active high |
| cam_data | input | 8 | Camera byte bus |
| wr_en | output | 1 | One-cycle frame-buffer write strobe |
| wr_addr | output | ADDR_W (19 by default) | Pixel address of the write |
| wr_data | output | WORD_W (12 by default) | Packed pixel word |

## Verification
The bench builds the block with a 16 by 4 frame (64 pixels, 6-bit address) and 4 bits per channel. With those values a full frame takes a few hundred clock cycles. That brings the saturation at the last address, and the writes that are dropped beyond it, within reach, which a 640 by 480 frame would not. The packing width stays at its default, so the colour word layout is the one used in the chip.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    typedef logic [7:0] cam_byte_t;

    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } phase_e;

    // Channel MSB positions inside the 16-bit {hi,lo} pixel word.
    localparam int RED_MSB = 15;
    localparam int GRN_MSB = 10;
    localparam int BLU_MSB = 4;
    localparam int PIX16_W = 16;

endpackage

// File: rtl/pcap_phase.sv
module pcap_phase
    import pcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vsync,
    input  logic      href,
    input  cam_byte_t din,
    output logic      pair_done,
    output cam_byte_t hi_byte
);

    typedef struct packed {
        phase_e    ph;
        cam_byte_t hi;
    } ph_state_t;

    ph_state_t s_d, s_q;
    logic      live;

    always_comb begin
        s_d  = s_q;
        live = href & ~vsync;
        if (!live) begin
            s_d.ph = PH_HI;
        end else if (s_q.ph == PH_HI) begin
            s_d.ph = PH_LO;
            s_d.hi = din;
        end else begin
            s_d.ph = PH_HI;
        end
        pair_done = live && (s_q.ph == PH_LO);
        hi_byte   = s_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_HI, hi: '0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pcap_pack.sv
module pcap_pack
    import pcap_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int WORD_W = 12
) (
    input  logic              luma_sel,
    input  cam_byte_t         hi_byte,
    input  cam_byte_t         lo_byte,
    output logic [WORD_W-1:0] word
);

    localparam int RGB_BITS = 3 * CH_W;

    logic [PIX16_W-1:0]  pix16;
    logic [RGB_BITS-1:0] rgb;
    logic [WORD_W-1:0]   rgb_word;
    logic [WORD_W-1:0]   luma_word;
    logic                unused_pix_bits;

    always_comb begin
        pix16 = {hi_byte, lo_byte};
        rgb   = {pix16[RED_MSB -: CH_W], pix16[GRN_MSB -: CH_W], pix16[BLU_MSB -: CH_W]};
    end

    assign unused_pix_bits = ^pix16;

    generate
        if (WORD_W > RGB_BITS) begin : g_rgb_pad
            assign rgb_word = {{(WORD_W - RGB_BITS){1'b0}}, rgb};
        end else begin : g_rgb_fit
            assign rgb_word = rgb;
        end

        if (WORD_W > 8) begin : g_luma_pad
            assign luma_word = {{(WORD_W - 8){1'b0}}, hi_byte};
        end else begin : g_luma_fit
            assign luma_word = hi_byte;
        end
    endgenerate

    always_comb begin
        word = luma_sel ? luma_word : rgb_word;
    end

endmodule

// File: rtl/pcap_addr.sv
module pcap_addr #(
    parameter int NPIX   = 307200,
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              room
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NPIX - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
        logic              full;
    } ag_state_t;

    ag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (vsync) begin
            s_d.cnt  = '0;
            s_d.full = 1'b0;
        end else if (adv && !s_q.full) begin
            if (s_q.cnt == LAST) begin
                s_d.full = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        cur_addr = s_q.cnt;
        room     = ~s_q.full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pix_capture_fb.sv
module pix_capture_fb
    import pcap_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    parameter int CH_W    = 4,
    localparam int NPIX     = FRAME_W * FRAME_H,
    localparam int ADDR_W   = (NPIX > 1) ? $clog2(NPIX) : 1,
    localparam int RGB_BITS = 3 * CH_W,
    localparam int WORD_W   = (RGB_BITS > 8) ? RGB_BITS : 8
) (
    input  logic              pclk,
    input  logic              rst_n,
    input  logic              luma_sel,
    input  logic              cam_vsync,
    input  logic              cam_href,
    input  logic [7:0]        cam_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_state_t;

    wr_state_t         r_d, r_q;
    logic              pair_done;
    cam_byte_t         hi_byte;
    logic [ADDR_W-1:0] cur_addr;
    logic              room;
    logic [WORD_W-1:0] packed_word;
    logic              fire;

    pcap_phase u_phase (
        .clk       (pclk),
        .rst_n     (rst_n),
        .vsync     (cam_vsync),
        .href      (cam_href),
        .din       (cam_data),
        .pair_done (pair_done),
        .hi_byte   (hi_byte)
    );

    pcap_pack #(
        .CH_W   (CH_W),
        .WORD_W (WORD_W)
    ) u_pack (
        .luma_sel (luma_sel),
        .hi_byte  (hi_byte),
        .lo_byte  (cam_data),
        .word     (packed_word)
    );

    pcap_addr #(
        .NPIX   (NPIX),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (pclk),
        .rst_n    (rst_n),
        .vsync    (cam_vsync),
        .adv      (pair_done),
        .cur_addr (cur_addr),
        .room     (room)
    );

    always_comb begin
        r_d    = r_q;
        fire   = pair_done & room;
        r_d.en = fire;
        if (fire) begin
            r_d.addr = cur_addr;
            r_d.data = packed_word;
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en   = r_q.en;
    assign wr_addr = r_q.addr;
    assign wr_data = r_q.data;

endmodule

// File: rtl/pcap_chk.sv
module pcap_chk #(
    parameter int NPIX   = 307200,
    parameter int ADDR_W = 19,
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync,
    input logic              href,
    input logic              luma_sel,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data
);

    logic              seen_q;
    logic              capped_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            capped_q <= 1'b0;
            last_q   <= '0;
        end else begin
            if (wr_en) begin
                seen_q <= 1'b1;
                last_q <= wr_addr;
                if (int'(wr_addr) == NPIX - 1) begin
                    capped_q <= 1'b1;
                end
            end
            if (vsync) begin
                seen_q   <= 1'b0;
                capped_q <= 1'b0;
            end
        end
    end

    // R6: a byte seen under frame sync never yields a write
    a_r6_quiet_after_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vsync) |-> !wr_en);

    // R6: first write of a frame lands at address zero
    a_r6_first_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !seen_q) |-> (wr_addr == '0));

    // R9: no write from a byte sampled with line-valid low
    a_r9_quiet_without_href: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(href) |-> !wr_en);

    // R4: strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3: luma words carry nothing above the byte
    a_r3_luma_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(luma_sel)) |-> ((wr_data >> 8) == '0));

    // R7: consecutive writes step the address by one
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seen_q) |-> (wr_addr == last_q + 1'b1));

    // R8: nothing after the last location until the next frame
    a_r8_no_write_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !capped_q);

    // R8: address stays inside the frame
    a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NPIX));

endmodule

bind pix_capture_fb pcap_chk #(
    .NPIX   (NPIX),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk      (pclk),
    .rst_n    (rst_n),
    .vsync    (cam_vsync),
    .href     (cam_href),
    .luma_sel (luma_sel),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/sim_pix_capture_fb.sv
module sim_pix_capture_fb;

    localparam int CLK_PERIOD = 10;
    localparam int FW   = 16;
    localparam int FH   = 4;
    localparam int NPX  = FW * FH;
    localparam int AW   = 6;
    localparam int WW   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          luma_sel = 1'b0;
    logic          vsync = 1'b0;
    logic          href = 1'b0;
    logic [7:0]    data = 8'h00;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [WW-1:0] wr_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    // behavioural reference state
    int  m_phase = 0;
    int  m_hold  = 0;
    int  m_cnt   = 0;
    int  e_en    = 0;
    int  e_addr  = 0;
    int  e_data  = 0;
    string e_tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    pix_capture_fb #(
        .FRAME_W (FW),
        .FRAME_H (FH),
        .CH_W    (4)
    ) u0 (
        .pclk      (clk),
        .rst_n     (rst_n),
        .luma_sel  (luma_sel),
        .cam_vsync (vsync),
        .cam_href  (href),
        .cam_data  (data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    function automatic int rgb_pack(int hi, int lo);
        return ((hi >> 4) << 8) | ((hi & 7) << 5) | ((lo >> 7) << 4) | ((lo >> 1) & 15);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check(e_tag, "wr_en", int'(wr_en), e_en);
        if (e_en != 0) begin
            check(e_tag, "wr_addr", int'(wr_addr), e_addr);
            check(e_tag, "wr_data", int'(wr_data), e_data);
        end
    endtask

    // one byte slot: compare last edge's result, drive, predict next edge
    task automatic step(logic v, logic h, logic [7:0] d, string tag);
        @(negedge clk);
        compare_outputs();
        vsync = v;
        href  = h;
        data  = d;
        e_tag = tag;
        e_en  = 0;
        if (v) begin
            m_phase = 0;
            m_cnt   = 0;
        end else if (!h) begin
            m_phase = 0;
        end else if (m_phase == 0) begin
            m_hold  = int'(d);
            m_phase = 1;
        end else begin
            m_phase = 0;
            if (m_cnt < NPX) begin
                e_en   = 1;
                e_addr = m_cnt;
                e_data = luma_sel ? m_hold : rgb_pack(m_hold, int'(d));
                m_cnt++;
            end
        end
    endtask

    task automatic send_line(int nbytes, int seed, string tag);
        for (int i = 0; i < nbytes; i++) begin
            step(1'b0, 1'b1, 8'((seed + i * 73) & 255), tag);
        end
    endtask

    task automatic idle(int n, logic v, string tag);
        for (int i = 0; i < n; i++) begin
            step(v, 1'b0, 8'((i * 29 + 5) & 255), tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs during and right after reset
        repeat (3) @(negedge clk);
        check("R1", "wr_en in reset", int'(wr_en), 0);
        check("R1", "wr_addr in reset", int'(wr_addr), 0);
        check("R1", "wr_data in reset", int'(wr_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "wr_en after reset", int'(wr_en), 0);
        check("R1", "wr_data after reset", int'(wr_data), 0);

        // R6: frame sync with data toggling and href high must not write
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'(8'hC3 + i), "R6");
        idle(2, 1'b0, "R6");

        // R2 / R7: colour line, several byte patterns
        send_line(16, 8'h5A, "R2");
        idle(3, 1'b0, "R9");
        send_line(8, 8'hFF, "R2");
        step(1'b0, 1'b1, 8'h00, "R2");
        step(1'b0, 1'b1, 8'h00, "R2");
        step(1'b0, 1'b1, 8'h80, "R2");
        step(1'b0, 1'b1, 8'h1E, "R2");
        idle(2, 1'b0, "R7");

        // R5: odd-length line, leftover byte dropped, next line realigned
        send_line(5, 8'h11, "R5");
        idle(2, 1'b0, "R5");
        send_line(6, 8'h3C, "R5");

        // R9: long gap with busy data between lines
        idle(7, 1'b0, "R9");
        send_line(4, 8'hE7, "R9");
        idle(1, 1'b0, "R9");

        // R3: luma-only mode
        luma_sel = 1'b1;
        send_line(10, 8'h90, "R3");
        idle(2, 1'b0, "R3");
        luma_sel = 1'b0;

        // R6: frame sync mid-line restarts at address 0
        send_line(3, 8'h21, "R6");
        idle(3, 1'b1, "R6");
        idle(1, 1'b0, "R6");
        send_line(6, 8'h47, "R6");
        idle(2, 1'b0, "R6");

        // R8: fill a whole frame and overrun it
        idle(2, 1'b1, "R8");
        for (int ln = 0; ln < FH; ln++) begin
            send_line(2 * FW, 8'(ln * 17 + 3), "R8");
            idle(2, 1'b0, "R8");
        end
        send_line(10, 8'h66, "R8");
        idle(2, 1'b0, "R8");
        check("R8", "pixels counted", m_cnt, NPX);

        // R6: new frame after saturation starts at 0 again
        idle(2, 1'b1, "R6");
        send_line(4, 8'hB2, "R6");
        idle(2, 1'b0, "R4");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule